// File: doc/BRIEF.md
# Card-to-Reader Subcarrier Uplink Transmitter

This block sends a card's reply to a reader by gating a subcarrier on and off in fixed bit slots. A controller hands it one request: up to twelve payload bits, their count, and a flag that picks a write acknowledge instead of a data reply. The request is issued at the moment the reader's last frame ended. That moment is the time reference. The block counts a fixed turnaround, which is longer for an acknowledge than for a data reply. It then drives one bit per slot on a registered modulation-enable output, least significant bit first. This output feeds the subcarrier gate. The subcarrier itself is produced elsewhere.

Time is measured in pulses of a `tick` strobe, one per subcarrier-derived timing period (about 4.7 µs). The keystream generator is outside the block. The block reads its current bit on `ks_bit` and asks for one step per cycle on `ks_adv`. A data reply masks each payload bit with the keystream. During the turnaround, the keystream is stepped once per elapsed bit period minus one. An acknowledge is a single plain 1 bit.

Top module: `uplink_tx`

## Requirements
- R1: While idle (`busy` low), a cycle with `req_valid` high accepts the request. `busy` is high from the next cycle until the frame ends. After reset, `busy`, `done`, `mod_en` and `ks_adv` are all low.
- R2: For a data reply (`req_ack` = 0), the first bit slot begins on the 70th tick after the accepting edge. `mod_en` stays low before that tick.
- R3: For a write acknowledge (`req_ack` = 1), the first bit slot begins on the 758th tick after the accepting edge. `mod_en` stays low before that tick.
- R4: Each bit slot lasts 21 ticks. `mod_en` changes only on an edge where `tick` is high. It keeps its value through a whole slot, including across equal consecutive bits.
- R5: A data reply sends `req_len` bits of `req_data`, starting from bit 0. The value of `mod_en` in slot k is `req_data[k]` XOR the keystream bit present when slot k starts. A value of 1 means modulation is on.
- R6: `ks_adv` pulses once per tick for the first (wait/21 − 1) ticks of the turnaround (2 for a reply, 35 for an acknowledge). It pulses once more at the start of every slot. A frame of L slots therefore produces (wait/21 − 1) + L steps in total.
- R7: A write acknowledge sends exactly one slot with `mod_en` high. `req_data` and `ks_bit` do not affect it.
- R8: On the tick that ends the last slot, `mod_en` goes low, `busy` goes low and `done` is high for exactly one cycle. `mod_en` is never high while `busy` is low.
- R9: A request presented while `busy` is high is ignored. It does not change the frame in progress, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timing strobe; all waits and slots are counted in these |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_data | input | MAX_BITS | Reply payload, bit 0 sent first |
| req_len | input | LEN_W | Number of payload bits, 1 to MAX_BITS |
| req_ack | input | 1 | 1 selects a write acknowledge, 0 a data reply |
| ks_bit | input | 1 | Current keystream bit from the external generator |
| ks_adv | output | 1 | Step request to the keystream generator, one step per high cycle |
| mod_en | output | 1 | Subcarrier modulation enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the last slot ends |

## Verification
The bench keeps the default parameters: 21-tick slots, a 70-tick reply turnaround, a 758-tick acknowledge turnaround and a 12-bit payload. With these values the full-length reply, the long acknowledge wait with its 35 keystream steps, and the exact first-slot boundary of both waits are all reached. The tick strobe is run both every cycle and every third cycle. This shows that every timing point follows the ticks and not the clock. A 7-bit shift-register model of the keystream lets each slot's expected masked bit be computed from the seed and the step count.

// File: rtl/uplink_pkg.sv
package uplink_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } tx_state_t;

  // keystream steps taken while waiting: one per whole slot of the wait, minus one
  function automatic int wait_steps(int wait_ticks, int slot_ticks);
    return wait_ticks / slot_ticks - 1;
  endfunction

endpackage

// File: rtl/uplink_tick_counter.sv
module uplink_tick_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick && (count != '0)) begin
      count <= count - W'(1);
    end
  end

endmodule

// File: rtl/uplink_bit_shifter.sv
module uplink_bit_shifter #(
  parameter int N  = 12,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [N-1:0]  load_data,
  input  logic [LW-1:0] load_len,
  input  logic          shift,
  output logic          head,
  output logic          next_bit,
  output logic          final_bit
);

  logic [N-1:0]  q;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      left <= '0;
    end else if (load) begin
      q    <= load_data;
      left <= load_len;
    end else if (shift) begin
      q    <= {1'b0, q[N-1:1]};
      left <= left - LW'(1);
    end
  end

  assign head      = q[0];
  assign next_bit  = q[1];
  assign final_bit = (left == LW'(1));

endmodule

// File: rtl/uplink_tx.sv
module uplink_tx #(
  parameter int SLOT_TICKS = 21,
  parameter int REPLY_WAIT = 70,
  parameter int ACK_WAIT   = 758,
  parameter int MAX_BITS   = 12,
  parameter int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                req_valid,
  input  logic [MAX_BITS-1:0] req_data,
  input  logic [LEN_W-1:0]    req_len,
  input  logic                req_ack,
  input  logic                ks_bit,
  output logic                ks_adv,
  output logic                mod_en,
  output logic                busy,
  output logic                done
);
  import uplink_pkg::*;

  localparam int LONG_WAIT  = (ACK_WAIT > REPLY_WAIT) ? ACK_WAIT : REPLY_WAIT;
  localparam int TMR_W      = $clog2(LONG_WAIT + 1);
  localparam int REPLY_SKIP = wait_steps(REPLY_WAIT, SLOT_TICKS);
  localparam int ACK_SKIP   = wait_steps(ACK_WAIT, SLOT_TICKS);
  localparam int LONG_SKIP  = (ACK_SKIP > REPLY_SKIP) ? ACK_SKIP : REPLY_SKIP;
  localparam int SKIP_W     = $clog2(LONG_SKIP + 2);

  tx_state_t state_q;
  logic      xor_q, mod_q, busy_q, done_q, ks_q;

  logic             accept, wait_end, slot_end, skip_step, tmr_last;
  logic [TMR_W-1:0] tmr_cnt, tmr_val;
  logic [SKIP_W-1:0] skip_cnt, skip_val;
  logic [LEN_W-1:0] len_eff;
  logic [MAX_BITS-1:0] data_eff;
  logic head, next_bit, final_bit, shift;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign tmr_last  = (tmr_cnt == TMR_W'(1));
  assign wait_end  = (state_q == ST_WAIT) && tick && tmr_last;
  assign slot_end  = (state_q == ST_SEND) && tick && tmr_last;
  assign skip_step = (state_q == ST_WAIT) && tick && (skip_cnt != '0);
  assign shift     = slot_end && !final_bit;

  assign tmr_val  = accept ? (req_ack ? TMR_W'(ACK_WAIT) : TMR_W'(REPLY_WAIT))
                           : TMR_W'(SLOT_TICKS);
  assign skip_val = req_ack ? SKIP_W'(ACK_SKIP) : SKIP_W'(REPLY_SKIP);

  always_comb begin
    if (req_ack) begin
      len_eff  = LEN_W'(1);
      data_eff = MAX_BITS'(1);
    end else begin
      data_eff = req_data;
      if (req_len == '0)
        len_eff = LEN_W'(1);
      else if (req_len > LEN_W'(MAX_BITS))
        len_eff = LEN_W'(MAX_BITS);
      else
        len_eff = req_len;
    end
  end

  // shared phase timer: turnaround first, then one slot at a time
  uplink_tick_counter #(.W(TMR_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (accept | wait_end | shift),
    .load_val (tmr_val),
    .tick     (tick && (state_q != ST_IDLE)),
    .count    (tmr_cnt)
  );

  // keystream steps owed during the turnaround
  uplink_tick_counter #(.W(SKIP_W)) u_skip (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (skip_val),
    .tick     (tick && (state_q == ST_WAIT)),
    .count    (skip_cnt)
  );

  uplink_bit_shifter #(.N(MAX_BITS), .LW(LEN_W)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (data_eff),
    .load_len  (len_eff),
    .shift     (shift),
    .head      (head),
    .next_bit  (next_bit),
    .final_bit (final_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      xor_q   <= 1'b0;
      mod_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ks_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ks_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_WAIT;
            busy_q  <= 1'b1;
            xor_q   <= !req_ack;
          end
        end
        ST_WAIT: begin
          if (skip_step) ks_q <= 1'b1;
          if (wait_end) begin
            state_q <= ST_SEND;
            mod_q   <= head ^ (xor_q & ks_bit);
            ks_q    <= 1'b1;
          end
        end
        ST_SEND: begin
          if (slot_end) begin
            if (final_bit) begin
              state_q <= ST_IDLE;
              mod_q   <= 1'b0;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              mod_q <= next_bit ^ (xor_q & ks_bit);
              ks_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mod_en = mod_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign ks_adv = ks_q;

endmodule

// File: rtl/uplink_tx_chk.sv
module uplink_tx_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic mod_en,
  input logic ks_adv
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy); // R1

  AST_MOD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(mod_en) |-> $past(tick)); // R4

  AST_KS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    ks_adv |-> busy); // R6

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && !mod_en)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mod_en); // R8

endmodule

bind uplink_tx uplink_tx_chk i_uplink_tx_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .mod_en    (mod_en),
  .ks_adv    (ks_adv)
);

// File: tb/test_uplink_tx.sv
module test_uplink_tx;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 21;
  localparam int RWAIT = 70;
  localparam int AWAIT = 758;
  localparam int NB = 12;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic req_valid = 1'b0;
  logic req_ack = 1'b0;
  logic [NB-1:0] req_data = '0;
  logic [LW-1:0] req_len = '0;
  logic ks_bit, ks_adv, mod_en, busy, done;

  logic [6:0] lfsr = 7'h01;
  logic [6:0] seed_val = 7'h01;
  logic seed_load = 1'b0;
  int ks_count = 0;
  int tick_div = 1;
  int div_cnt = 0;
  int checks = 0;
  int fails = 0;

  uplink_tx i_uplink_tx (
    .clk(clk), .rst(rst), .tick(tick), .req_valid(req_valid),
    .req_data(req_data), .req_len(req_len), .req_ack(req_ack),
    .ks_bit(ks_bit), .ks_adv(ks_adv), .mod_en(mod_en),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] lfsr_next(logic [6:0] l);
    return {l[5:0], l[6] ^ l[5]};
  endfunction

  function automatic logic ks_at(logic [6:0] seed, int n);
    logic [6:0] l = seed;
    for (int i = 0; i < n; i++) l = lfsr_next(l);
    return l[6];
  endfunction

  // keystream generator model and step counter
  assign ks_bit = lfsr[6];
  always @(posedge clk) begin
    if (seed_load) begin
      lfsr     <= seed_val;
      ks_count <= 0;
    end else if (ks_adv) begin
      lfsr     <= lfsr_next(lfsr);
      ks_count <= ks_count + 1;
    end
  end

  always @(negedge clk) begin
    if (div_cnt >= tick_div - 1) begin
      tick    <= 1'b1;
      div_cnt <= 0;
    end else begin
      tick    <= 1'b0;
      div_cnt <= div_cnt + 1;
    end
  end

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic run_frame(logic [NB-1:0] data, int len, bit ack, logic [6:0] seed, bit poke);
    int w, skip, nslots;
    logic exp;
    w = ack ? AWAIT : RWAIT;
    skip = w / SLOT - 1;
    nslots = ack ? 1 : len;
    @(negedge clk);
    seed_val = seed;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    req_valid = 1'b1;
    req_data = data;
    req_len = LW'(len);
    req_ack = ack;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "busy after accept", busy, 1);
    wait_ticks(w - 1);
    @(negedge clk);
    chk(ack ? "R3" : "R2", "mod_en one tick before first slot", mod_en, 0);
    wait_ticks(1);
    for (int k = 0; k < nslots; k++) begin
      @(negedge clk);
      exp = ack ? 1'b1 : (data[k] ^ ks_at(seed, skip + k));
      chk(ack ? "R7" : "R5", $sformatf("slot %0d start", k), mod_en, exp);
      if (poke && k == 2) begin
        req_valid = 1'b1;
        req_ack = !ack;
        req_data = ~data;
        wait_ticks(3);
        @(negedge clk);
        req_valid = 1'b0;
        wait_ticks(SLOT - 4);
      end else begin
        wait_ticks(SLOT - 1);
      end
      @(negedge clk);
      chk("R4", $sformatf("slot %0d held to end", k), mod_en, exp);
      wait_ticks(1);
    end
    @(negedge clk);
    chk("R8", "mod_en off after last slot", mod_en, 0);
    chk("R8", "done pulse", done, 1);
    chk("R8", "busy released", busy, 0);
    chk("R6", "keystream steps", ks_count, skip + nslots);
    @(negedge clk);
    chk("R8", "done lasts one cycle", done, 0);
    if (poke) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk("R9", "no frame from request seen while busy", busy | mod_en, 0);
      end
    end
  endtask

  task automatic t_reset;
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset mod_en", mod_en, 0);
    chk("R1", "reset ks_adv", ks_adv, 0);
  endtask

  task automatic t_reply_full;
    run_frame(12'hA5C, 12, 1'b0, 7'h5B, 1'b0);
  endtask

  task automatic t_reply_runs;
    run_frame(12'h3F0, 12, 1'b0, 7'h11, 1'b0);
  endtask

  task automatic t_ack;
    run_frame(12'h000, 7, 1'b1, 7'h2A, 1'b0);
  endtask

  task automatic t_sparse_tick;
    @(negedge clk);
    tick_div = 3;
    run_frame(12'h016, 5, 1'b0, 7'h77, 1'b0);
    @(negedge clk);
    tick_div = 1;
  endtask

  task automatic t_busy_ignore;
    run_frame(12'h9C3, 8, 1'b0, 7'h33, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reply_full();
    t_reply_runs();
    t_ack();
    t_sparse_tick();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule